// File: doc/BRIEF.md
# USB Low/Full-Speed Packet Serializer

This block turns one USB packet into timed line states on a differential output pair with an output enable. A packet is offered on a single byte stream with a valid/ready handshake. The first beat carries the packet identifier and two control flags. The beats after it carry the payload. The block adds the sync pattern and the complemented identifier byte. When asked, it appends a CRC16 computed on the fly. It then bit-stuffs and NRZI-encodes the serial stream. It finishes with the end-of-packet line sequence and releases the bus.

The bit period is a number of clock cycles given by a clocks-per-bit input. At low speed the block stretches it eightfold. The speed input also swaps which line carries the idle J level. The speed and the period are captured when a packet is accepted, so the host may only change them between packets. Payload bytes are pulled just in time: the block asks for the next byte during a single bit slot, shortly before the last bit of the current byte leaves. A source that misses that slot ends the payload at that point.

Top module: `usb_pkt_tx`

## Requirements
- R1: After reset the bus is released: usb_oe, usb_dp and usb_dm are 0, and in_ready is 1.
- R2: Accepting a first beat (in_valid with in_ready while idle) raises usb_oe in the next cycle. One bit slot of J follows, then the sync byte 0x80 sent least significant bit first.
- R3: In the first beat, in_data[3:0] is the PID and in_data[7:4] is ignored. in_crc=1 requests a CRC16 and in_last=1 means no payload. The PID goes on the line as the byte {~PID, PID}, least significant bit first.
- R4: Payload bytes are sent least significant bit first, in order. For each byte, in_ready is high during only one bit slot, and the byte is taken on a cycle where in_valid and in_ready are both high. in_last=1 on a payload beat marks the final byte.
- R5: After six consecutive 1 bits, a 0 bit is inserted and the run count restarts. This also applies after the last data bit, before the end-of-packet sequence.
- R6: NRZI coding: a 1 bit keeps the line level and a 0 bit toggles it, starting from J.
- R7: With in_crc=1, the payload is followed by a CRC16 sent low byte first. The CRC uses polynomial 0x8005, is preset to all ones, covers the payload bits LSB first (not the PID), and is bit-reversed and inverted at the end.
- R8: The packet ends with two bit slots of SE0 (dp=dm=0) and one slot of J, after which usb_oe falls.
- R9: J is dp=1/dm=0 at full speed (low_speed=0) and dp=0/dm=1 at low speed (low_speed=1). K is the opposite state, and dp and dm are never both 1.
- R10: Every bit slot lasts clk_per_bit cycles at full speed and 8*clk_per_bit cycles at low speed. Both values are sampled when the first beat is accepted, so changes to low_speed during a packet have no effect on that packet.
- R11: If no payload byte has been accepted when one is needed, the payload ends there. The CRC, if requested, covers only the bytes taken so far, and the end-of-packet sequence follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_speed | input | 1 | 1 selects low speed: 8x bit period and swapped J polarity |
| clk_per_bit | input | DIV_W | Clock cycles per full-speed bit (at least 2) |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_data | input | 8 | PID in [3:0] on the first beat, payload byte afterwards |
| in_last | input | 1 | No further payload byte after this beat |
| in_crc | input | 1 | First beat only: append CRC16 |
| usb_dp | output | 1 | D+ line level |
| usb_dm | output | 1 | D- line level |
| usb_oe | output | 1 | Line driver enable |

## Verification
The assertions watch four things on every cycle. The two lines are never high together. A packet always opens on J right after its first beat is taken. The last driven state before the enable drops is J. The captured speed never moves while a packet is on the wire. The bit-level content can only be shown by the bench's scenarios, because it checks the whole line trace of each packet against a sequence it builds itself. That content covers the sync and PID framing, the stuffing after runs of ones (including the run at the end of a packet), the NRZI levels, the CRC value, the slot lengths at both speeds, early payload end when the source falls short, and immunity to a mid-packet speed change.

// File: rtl/usb_pkt_tx.sv
module usb_pkt_tx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_speed,
  input  logic [DIV_W-1:0] clk_per_bit,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_crc,
  output logic             usb_dp,
  output logic             usb_dm,
  output logic             usb_oe
);
  localparam int PW = DIV_W + 3;

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_PID, S_DATA, S_CRCL, S_CRCH, S_EOP} st_t;

  st_t          st;
  logic [PW-1:0] cnt, per;
  logic         ls_q, crc_en, done_q, have, nxt_last, lvl, se0;
  logic [3:0]   pid_q;
  logic [7:0]   sh, nxt;
  logic [2:0]   bi, ones;
  logic [1:0]   ecnt;
  logic [15:0]  crc, crc_nx, crc_fin, crc_o;

  wire tick  = (st != S_IDLE) && (cnt == per - PW'(1));
  wire stuff = (ones == 3'd6);
  wire bitv  = sh[0];
  wire fb    = bitv ^ crc[15];

  assign crc_nx  = {crc[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
  assign crc_fin = (st == S_DATA) ? crc_nx : crc;

  always_comb
    for (int i = 0; i < 16; i++) crc_o[i] = ~crc_fin[15-i];

  assign in_ready = (st == S_IDLE) ||
                    ((st == S_PID || st == S_DATA) && !done_q && !have && bi == 3'd7 && !tick);

  assign usb_oe = (st != S_IDLE);
  assign usb_dp = usb_oe && !se0 && (lvl ^ ls_q);
  assign usb_dm = usb_oe && !se0 && (!lvl ^ ls_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; per <= PW'(1); ls_q <= 1'b0;
      crc_en <= 1'b0; done_q <= 1'b1; have <= 1'b0; nxt_last <= 1'b0;
      lvl <= 1'b1; se0 <= 1'b0; pid_q <= '0; sh <= '0; nxt <= '0;
      bi <= '0; ones <= '0; ecnt <= '0; crc <= 16'hFFFF;
    end else if (st == S_IDLE) begin
      if (in_valid) begin
        st <= S_SYNC; cnt <= '0; ls_q <= low_speed;
        per <= low_speed ? {clk_per_bit, 3'b000} : PW'(clk_per_bit);
        pid_q <= in_data[3:0]; crc_en <= in_crc; done_q <= in_last;
        have <= 1'b0; lvl <= 1'b1; se0 <= 1'b0; sh <= 8'h80;
        bi <= '0; ones <= '0; ecnt <= '0; crc <= 16'hFFFF;
      end
    end else begin
      cnt <= tick ? '0 : cnt + PW'(1);
      if (in_valid && in_ready) begin
        nxt <= in_data; nxt_last <= in_last; have <= 1'b1;
      end
      if (tick) begin
        if (stuff) begin
          lvl <= ~lvl; ones <= '0;
        end else if (st == S_EOP) begin
          ecnt <= ecnt + 2'd1;
          ones <= '0;
          case (ecnt)
            2'd0, 2'd1: se0 <= 1'b1;
            2'd2: begin se0 <= 1'b0; lvl <= 1'b1; end
            default: begin se0 <= 1'b0; st <= S_IDLE; end
          endcase
        end else begin
          if (!bitv) lvl <= ~lvl;
          ones <= bitv ? ones + 3'd1 : 3'd0;
          if (st == S_DATA) crc <= crc_nx;
          sh <= sh >> 1;
          bi <= bi + 3'd1;
          if (bi == 3'd7) begin
            case (st)
              S_SYNC: begin st <= S_PID; sh <= {~pid_q, pid_q}; end
              S_PID, S_DATA: begin
                if (!done_q && have) begin
                  st <= S_DATA; sh <= nxt; done_q <= nxt_last; have <= 1'b0;
                end else if (crc_en) begin
                  st <= S_CRCL; sh <= crc_o[7:0];
                end else begin
                  st <= S_EOP; ecnt <= '0;
                end
              end
              S_CRCL: begin st <= S_CRCH; sh <= crc_o[15:8]; end
              default: begin st <= S_EOP; ecnt <= '0; end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/usb_pkt_tx_chk.sv
module usb_pkt_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic dp,
  input logic dm,
  input logic oe,
  input logic vld,
  input logic rdy,
  input logic ls
);
  wire j_now = ls ? (dm && !dp) : (dp && !dm);

  // R9
  line_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) !(dp && dm));

  // R2
  start_on_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && rdy && !oe) |=> (oe && j_now));

  // R8
  release_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> $past(j_now));

  // R10
  speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe)) |-> $stable(ls));
endmodule

bind usb_pkt_tx usb_pkt_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dp(usb_dp), .dm(usb_dm), .oe(usb_oe),
  .vld(in_valid), .rdy(in_ready), .ls(ls_q)
);

// File: tb/usb_pkt_tx_tb_top.sv
module usb_pkt_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, low_speed = 1'b0;
  logic [7:0] clk_per_bit = 8'd4;
  logic in_valid = 1'b0, in_last = 1'b0, in_crc = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, usb_dp, usb_dm, usb_oe;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  usb_pkt_tx #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .low_speed(low_speed), .clk_per_bit(clk_per_bit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_crc(in_crc), .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe)
  );

  // fields: [19] low speed, [18] crc, [17:14] pid, [13:8] bytes, [7:0] pattern (FF = all ones)
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 1'b0, 4'h2, 6'd0, 8'h00},
    {1'b0, 1'b1, 4'h3, 6'd4, 8'h11},
    {1'b0, 1'b1, 4'hB, 6'd5, 8'hFF},
    {1'b1, 1'b1, 4'h3, 6'd3, 8'h5A},
    {1'b1, 1'b0, 4'h9, 6'd2, 8'hC3},
    {1'b0, 1'b1, 4'h3, 6'd0, 8'h00}
  };

  logic [7:0] pl [64];
  bit   bq [2048];
  int   ex [2048];
  int   got [2048];
  int   elen, glen, gcyc, acc;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic build(input bit crc_on, input logic [3:0] pid, input int n);
    int nb = 0, k = 0, run = 0, lv = 1;
    logic [15:0] c = 16'hFFFF, r;
    logic [7:0] hdr;
    hdr = {~pid, pid};
    for (int i = 0; i < 8; i++) begin bq[nb] = (i == 7); nb++; end
    for (int i = 0; i < 8; i++) begin bq[nb] = hdr[i]; nb++; end
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++) begin
        bq[nb] = pl[b][i]; nb++;
        c = {c[14:0], 1'b0} ^ ((pl[b][i] ^ c[15]) ? 16'h8005 : 16'h0000);
      end
    for (int i = 0; i < 16; i++) r[i] = ~c[15-i];
    if (crc_on) for (int i = 0; i < 16; i++) begin bq[nb] = r[i]; nb++; end
    ex[k] = 1; k++;
    for (int i = 0; i < nb; i++) begin
      if (!bq[i]) lv = 3 - lv;
      ex[k] = lv; k++;
      run = bq[i] ? run + 1 : 0;
      if (run == 6) begin lv = 3 - lv; ex[k] = lv; k++; run = 0; end
    end
    ex[k] = 0; ex[k+1] = 0; ex[k+2] = 1;
    elen = k + 3;
  endtask

  task automatic run_pkt(input bit ls, input bit crc_on, input logic [3:0] pid, input int n,
                         input logic [7:0] pat, input bit starve, input bit flip, input string tag);
    int per = ls ? 32 : 4;
    int bad = -1;
    for (int i = 0; i < n; i++) pl[i] = (pat == 8'hFF) ? 8'hFF : 8'(pat + i * 29);
    build(crc_on, pid, starve ? 0 : n);
    acc = 0; glen = 0; gcyc = 0;
    @(negedge clk);
    low_speed = ls; in_valid = 1'b1; in_data = {4'hA, pid};
    in_last = (n == 0) && !starve; in_crc = crc_on;
    @(posedge clk);
    fork
      begin
        if (!starve)
          for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_data = pl[i]; in_last = (i == n - 1); in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            acc++;
          end
        @(negedge clk);
        in_valid = 1'b0;
        if (flip) begin repeat (40) @(negedge clk); low_speed = ~ls; end
      end
      begin
        @(negedge clk);
        while (usb_oe) begin
          if (gcyc % per == per / 2 && glen < 2048) begin
            got[glen] = (!usb_dp && !usb_dm) ? 0 :
                        (usb_dp && !usb_dm) ? (ls ? 2 : 1) :
                        (!usb_dp && usb_dm) ? (ls ? 1 : 2) : 3;
            glen++;
          end
          gcyc++;
          @(negedge clk);
        end
      end
    join
    for (int i = 0; i < elen && i < glen; i++)
      if (bad < 0 && got[i] != ex[i]) bad = i;
    check(glen == elen, {tag, " R8 slot count"}, glen, elen);
    check(bad < 0, {tag, " line symbols"}, (bad < 0) ? 0 : got[bad], (bad < 0) ? 0 : ex[bad]);
    check(gcyc == elen * per, {"R10 cycles ", tag}, gcyc, elen * per);
    check(acc == (starve ? 0 : n), {"R4 bytes taken ", tag}, acc, starve ? 0 : n);
    low_speed = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(usb_oe == 1'b0, "R1 oe", usb_oe, 0);
    check(usb_dp == 1'b0, "R1 dp", usb_dp, 0);
    check(usb_dm == 1'b0, "R1 dm", usb_dm, 0);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);

    for (int v = 0; v < 6; v++)
      run_pkt(VEC[v][19], VEC[v][18], VEC[v][17:14], int'(VEC[v][13:8]), VEC[v][7:0],
              1'b0, 1'b0, $sformatf("vec%0d R2 R3 R5 R6 R7 R9", v));

    // R11: payload promised but never supplied
    run_pkt(1'b0, 1'b1, 4'hC, 2, 8'h40, 1'b1, 1'b0, "R11 starve");
    // R10: speed input changed during a full-speed packet
    run_pkt(1'b0, 1'b1, 4'h3, 3, 8'h77, 1'b0, 1'b1, "R10 speed flip");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule